// File: doc/BRIEF.md
# Keyed System Control Register Bank

This block is the control and status register bank of a processor core module. It sits on a simple 32-bit register bus with byte addresses that are aligned to words. It returns fixed identity and status words and holds the primary and auxiliary oscillator settings. A 16-bit unlock key guards both oscillator registers. The bank also holds the SDRAM configuration word, the init word, a volatile flag register and a non-volatile flag register, and a read-only window onto the memory module's identification bytes.

A control word drives three outputs: a boot-memory remap select, an LED, and a one-cycle board reset request. When the reset request fires, the bank clears its own volatile state. The non-volatile flags survive it, and only the power-on reset `rst` clears them. The memory-size parameter sets the SDRAM size code and the size byte of the identification window. Read data and the error strobe arrive one cycle after the access.

Top module: `sysctl_regbank`

## Requirements
- R1: A read returns its data on `bus_rdata` in the cycle after the access, and `bus_rdata` is zero when no read was accepted. Byte address 0x00 reads 0x411A3001, 0x10 reads 0x00100000 and 0x04 reads zero.
- R2: A write to the lock word (0x14) keeps only data bits 15:0. A read of 0x14 returns 0x0001A05F while the stored value is 0xA05F, and otherwise the stored value zero-extended. The lock word resets to 0.
- R3: Writes to the primary oscillator word (0x08) and the auxiliary oscillator word (0x1C) take effect only while the lock word holds 0xA05F. At any other time they leave the stored value unchanged.
- R4: After `rst`, 0x08 reads 0x01000048, 0x1C reads 0x0007FEFF and the init word 0x24 reads 0x00000112.
- R5: The SDRAM word (0x20) resets to 0x00011122 ORed with a size code: 0x10 if MEM_MB >= 256, 0x0C if >= 128, 0x08 if >= 64, 0x04 if >= 32, else 0. This is 0x0001112E at the default MEM_MB = 128. Writes to 0x20 and 0x24 store the full word.
- R6: A write to 0x30 ORs the data into the volatile flags, and a write to 0x34 clears the flag bits that are set in the data. 0x38 and 0x3C do the same for the non-volatile flags. 0x30 and 0x38 read the flags back.
- R7: A write to the control word (0x0C) stores bit 0 as `led_on` and bit 2 as `remap_sel`, both visible from the following cycle. A read of 0x0C returns those two bits in place and zero elsewhere, so bit 3 always reads zero. The control bits change only on a control write or a reset request.
- R8: Writing 0x0C with bit 3 set pulses `reset_req` high for exactly the next cycle. That pulse clears the control bits and the volatile flags. The non-volatile flags keep their value, and only `rst` clears them.
- R9: Byte address 0x100 + 4*k (k = 0..31) reads identification byte k, zero-extended. Byte 0 is 0x80, byte 2 is 0x04, and byte 31 is 64/32/16/4/2 for the same MEM_MB bands as R5 (0x20 at the default). Addresses 0x180 to 0x1FF read zero.
- R10: Words 0x80 to 0x8C read zero, ignore writes and raise no error.
- R11: An access to an undecoded address returns zero and raises `bus_err` for one cycle, with the same timing as read data. Undecoded means an unaligned address, an address outside the map, a write to a read-only word, or a read of a write-only word (0x34, 0x3C). Decoded accesses never raise `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (9) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| bus_err | output | 1 | One-cycle error strobe for undecoded accesses |
| remap_sel | output | 1 | Boot-memory remap select (control bit 2) |
| reset_req | output | 1 | One-cycle board reset request |
| led_on | output | 1 | LED drive (control bit 0) |

## Verification
The assertions are checked on every cycle. They cover the following:
- Locked oscillator writes leave the oscillator values unchanged.
- The control bits hold between control writes.
- A reset request clears the outputs and the volatile flags but leaves the non-volatile flags as they were.
- The upper identification window reads zero.
- An error strobe always follows an access.

Only the bench's scenarios can show the rest:
- the exact constants and reset values;
- the rule that keeps 16 bits of the lock word and the value its read returns;
- how the set and clear addresses combine;
- the contents of the identification window;
- which offsets count as undecoded.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam logic [31:0] ID_WORD    = 32'h411A3001;
    localparam logic [31:0] STAT_WORD  = 32'h00100000;
    localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
    localparam logic [31:0] OSC_RST    = 32'h01000048;
    localparam logic [31:0] AUX_RST    = 32'h0007FEFF;
    localparam logic [31:0] SDRAM_BASE = 32'h00011122;
    localparam logic [31:0] INIT_RST   = 32'h00000112;

    typedef enum logic [3:0] {
        RG_NONE, RG_ID, RG_PROC, RG_OSC, RG_CTRL, RG_STAT, RG_LOCK, RG_AUX,
        RG_SDRAM, RG_INIT, RG_FLAG_SET, RG_FLAG_CLR, RG_NV_SET, RG_NV_CLR,
        RG_VOLT, RG_WIN
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e    sel;
        logic        rd_ok;
        logic        wr_ok;
        logic [4:0]  win_idx;
        logic        win_hi;
    } dec_t;

    function automatic logic [4:0] size_code(input int mb);
        if (mb >= 256)      return 5'h10;
        else if (mb >= 128) return 5'h0C;
        else if (mb >= 64)  return 5'h08;
        else if (mb >= 32)  return 5'h04;
        else                return 5'h00;
    endfunction

    function automatic logic [7:0] size_byte(input int mb);
        if (mb >= 256)      return 8'd64;
        else if (mb >= 128) return 8'd32;
        else if (mb >= 64)  return 8'd16;
        else if (mb >= 32)  return 8'd4;
        else                return 8'd2;
    endfunction

    function automatic logic [7:0] id_byte(input logic [4:0] idx, input int mb);
        case (idx)
            5'd0:  return 8'd128;
            5'd1:  return 8'd8;
            5'd2:  return 8'd4;
            5'd3:  return 8'd11;
            5'd4:  return 8'd9;
            5'd5:  return 8'd1;
            5'd6:  return 8'd64;
            5'd8:  return 8'd2;
            5'd9:  return 8'hA0;
            5'd10: return 8'hA0;
            5'd13: return 8'd8;
            5'd15: return 8'd1;
            5'd16: return 8'h0E;
            5'd17: return 8'd4;
            5'd18: return 8'h1C;
            5'd19: return 8'd1;
            5'd20: return 8'd2;
            5'd21: return 8'h20;
            5'd22: return 8'hC0;
            5'd27: return 8'h30;
            5'd28: return 8'h28;
            5'd29: return 8'h30;
            5'd30: return 8'h28;
            5'd31: return size_byte(mb);
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic [AW-1:0] addr,
    output dec_t          dec
);
    localparam int WORD_LSB = 2;
    localparam int WORD_MSB = 8;

    logic [WORD_MSB-WORD_LSB:0] word;
    logic                       in_map;

    assign word   = addr[WORD_MSB:WORD_LSB];
    assign in_map = ((addr >> (WORD_MSB + 1)) == '0) && (addr[1:0] == 2'b00);

    always_comb begin
        dec         = '0;
        dec.sel     = RG_NONE;
        dec.win_idx = word[4:0];
        dec.win_hi  = word[5];
        if (in_map) begin
            if (word[6]) begin
                dec.sel   = RG_WIN;
                dec.rd_ok = 1'b1;
            end else begin
                case (word)
                    7'd0:  begin dec.sel = RG_ID;       dec.rd_ok = 1'b1; end
                    7'd1:  begin dec.sel = RG_PROC;     dec.rd_ok = 1'b1; end
                    7'd2:  begin dec.sel = RG_OSC;      dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; end
                    7'd3:  begin dec.sel = RG_CTRL;     dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; end
                    7'd4:  begin dec.sel = RG_STAT;     dec.rd_ok = 1'b1; end
                    7'd5:  begin dec.sel = RG_LOCK;     dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; end
                    7'd7:  begin dec.sel = RG_AUX;      dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; end
                    7'd8:  begin dec.sel = RG_SDRAM;    dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; end
                    7'd9:  begin dec.sel = RG_INIT;     dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; end
                    7'd12: begin dec.sel = RG_FLAG_SET; dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; end
                    7'd13: begin dec.sel = RG_FLAG_CLR; dec.wr_ok = 1'b1; end
                    7'd14: begin dec.sel = RG_NV_SET;   dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; end
                    7'd15: begin dec.sel = RG_NV_CLR;   dec.wr_ok = 1'b1; end
                    7'd32, 7'd33, 7'd34, 7'd35:
                           begin dec.sel = RG_VOLT;     dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; end
                    default: dec.sel = RG_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sysctl_keyed_osc.sv
module sysctl_keyed_osc
    import sysctl_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_lock,
    input  logic          wr_osc,
    input  logic          wr_aux,
    input  logic [DW-1:0] wdata,
    output logic [15:0]   lock_q,
    output logic [DW-1:0] osc_q,
    output logic [DW-1:0] aux_q
);
    logic unlocked;
    assign unlocked = (lock_q == UNLOCK_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= '0;
            osc_q  <= OSC_RST;
            aux_q  <= AUX_RST;
        end else begin
            if (wr_lock)             lock_q <= wdata[15:0];
            if (wr_osc && unlocked)  osc_q  <= wdata;
            if (wr_aux && unlocked)  aux_q  <= wdata;
        end
    end

    AST_OSC_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_osc && lock_q != UNLOCK_KEY) |=> $stable(osc_q)); // R3
    AST_AUX_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_aux && lock_q != UNLOCK_KEY) |=> $stable(aux_q)); // R3
endmodule

// File: rtl/sysctl_flag_reg.sv
module sysctl_flag_reg #(
    parameter int DW          = 32,
    parameter bit CLR_ON_SOFT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          soft_clr,
    input  logic          set_wr,
    input  logic          clr_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] val_q
);
    logic [DW-1:0] base, nxt;

    generate
        if (CLR_ON_SOFT) begin : g_volatile
            assign base = soft_clr ? '0 : val_q;
            AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (rst)
                (soft_clr && !set_wr) |=> (val_q == '0)); // R8
        end else begin : g_keep
            logic unused_soft;
            assign unused_soft = soft_clr;
            assign base = val_q;
            AST_SOFT_KEEPS: assert property (@(posedge clk) disable iff (rst)
                (soft_clr && !set_wr && !clr_wr) |=> $stable(val_q)); // R8
        end
    endgenerate

    always_comb begin
        nxt = base;
        if (set_wr) nxt = nxt | wdata;
        if (clr_wr) nxt = nxt & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) val_q <= '0;
        else     val_q <= nxt;
    end
endmodule

// File: rtl/sysctl_idrom.sv
module sysctl_idrom
    import sysctl_pkg::*;
#(
    parameter int MEM_MB = 128
) (
    input  logic [4:0] idx,
    input  logic       hi,
    output logic [7:0] data
);
    assign data = hi ? 8'h00 : id_byte(idx, MEM_MB);
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int AW     = 9,
    parameter int MEM_MB = 128
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          bus_err,
    output logic          remap_sel,
    output logic          reset_req,
    output logic          led_on
);
    localparam int          DW        = 32;
    localparam logic [31:0] SDRAM_RST = SDRAM_BASE | {27'b0, size_code(MEM_MB)};

    dec_t          dec;
    logic          wr_en, rd_en, bad;
    logic [15:0]   lock_q;
    logic [DW-1:0] osc_q, aux_q, sdram_q, init_q, flags_q, nv_q, rd_mux;
    logic [1:0]    ctrl_q;
    logic [7:0]    id_data;
    logic          ctrl_wr;

    sysctl_decode #(.AW(AW)) u_dec (.addr(bus_addr), .dec(dec));

    assign wr_en   = bus_sel && bus_wr && dec.wr_ok;
    assign rd_en   = bus_sel && !bus_wr && dec.rd_ok;
    assign bad     = bus_sel && (bus_wr ? !dec.wr_ok : !dec.rd_ok);
    assign ctrl_wr = wr_en && dec.sel == RG_CTRL;

    sysctl_keyed_osc #(.DW(DW)) u_osc (
        .clk(clk), .rst(rst),
        .wr_lock(wr_en && dec.sel == RG_LOCK),
        .wr_osc (wr_en && dec.sel == RG_OSC),
        .wr_aux (wr_en && dec.sel == RG_AUX),
        .wdata(bus_wdata), .lock_q(lock_q), .osc_q(osc_q), .aux_q(aux_q)
    );

    sysctl_flag_reg #(.DW(DW), .CLR_ON_SOFT(1'b1)) u_flags (
        .clk(clk), .rst(rst), .soft_clr(reset_req),
        .set_wr(wr_en && dec.sel == RG_FLAG_SET),
        .clr_wr(wr_en && dec.sel == RG_FLAG_CLR),
        .wdata(bus_wdata), .val_q(flags_q)
    );

    sysctl_flag_reg #(.DW(DW), .CLR_ON_SOFT(1'b0)) u_nvflags (
        .clk(clk), .rst(rst), .soft_clr(reset_req),
        .set_wr(wr_en && dec.sel == RG_NV_SET),
        .clr_wr(wr_en && dec.sel == RG_NV_CLR),
        .wdata(bus_wdata), .val_q(nv_q)
    );

    sysctl_idrom #(.MEM_MB(MEM_MB)) u_idrom (
        .idx(dec.win_idx), .hi(dec.win_hi), .data(id_data)
    );

    // ctrl_q = {remap, led}; the reset-request pulse wins over a write
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            reset_req <= 1'b0;
            sdram_q   <= SDRAM_RST;
            init_q    <= INIT_RST;
        end else begin
            reset_req <= ctrl_wr && bus_wdata[3];
            if (reset_req)    ctrl_q <= '0;
            else if (ctrl_wr) ctrl_q <= {bus_wdata[2], bus_wdata[0]};
            if (wr_en && dec.sel == RG_SDRAM) sdram_q <= bus_wdata;
            if (wr_en && dec.sel == RG_INIT)  init_q  <= bus_wdata;
        end
    end

    assign remap_sel = ctrl_q[1];
    assign led_on    = ctrl_q[0];

    always_comb begin
        case (dec.sel)
            RG_ID:       rd_mux = ID_WORD;
            RG_STAT:     rd_mux = STAT_WORD;
            RG_OSC:      rd_mux = osc_q;
            RG_AUX:      rd_mux = aux_q;
            RG_CTRL:     rd_mux = {29'b0, ctrl_q[1], 1'b0, ctrl_q[0]};
            RG_LOCK:     rd_mux = (lock_q == UNLOCK_KEY) ? {15'b0, 1'b1, lock_q}
                                                         : {16'b0, lock_q};
            RG_SDRAM:    rd_mux = sdram_q;
            RG_INIT:     rd_mux = init_q;
            RG_FLAG_SET: rd_mux = flags_q;
            RG_NV_SET:   rd_mux = nv_q;
            RG_WIN:      rd_mux = {24'b0, id_data};
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= rd_en ? rd_mux : '0;
            bus_err   <= bad;
        end
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_wr && !reset_req) |=> $stable(ctrl_q)); // R7
    AST_REQ_CLEARS_OUT: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> (!led_on && !remap_sel)); // R8
    AST_UPPER_WIN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && dec.sel == RG_WIN && dec.win_hi) |=> (bus_rdata == '0)); // R9
    AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_sel)); // R11
endmodule

// File: tb/sysctl_regbank_bench.sv
module sysctl_regbank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err, remap_sel, reset_req, led_on;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        bit          chk_data;
        logic [31:0] data;
        bit          err;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    logic took = 1'b0;

    always #2.5 clk = ~clk;

    sysctl_regbank u_sysctl_regbank (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .remap_sel(remap_sel), .reset_req(reset_req),
        .led_on(led_on)
    );

    always @(posedge clk) took <= bus_sel;

    // monitor: compare results with the scoreboard
    always @(negedge clk) begin
        if (took) begin
            exp_t e;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL scoreboard: result with no expectation");
            end else begin
                e = exp_q.pop_front();
                checks++;
                if (e.chk_data && bus_rdata !== e.data) begin
                    failures++;
                    $display("FAIL %s rdata actual=%h expected=%h", e.tag, bus_rdata, e.data);
                end
                if (bus_err !== e.err) begin
                    failures++;
                    $display("FAIL %s err actual=%b expected=%b", e.tag, bus_err, e.err);
                end
            end
        end
    end

    task automatic rd(input logic [8:0] a, input logic [31:0] d, input bit e, input string tag);
        exp_t x;
        x.chk_data = 1'b1; x.data = d; x.err = e; x.tag = tag;
        exp_q.push_back(x);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d, input bit e, input string tag);
        exp_t x;
        x.chk_data = 1'b0; x.data = '0; x.err = e; x.tag = tag;
        exp_q.push_back(x);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pin(input logic act, input logic expv, input string what);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", what, act, expv);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        pin(led_on, 1'b0, "R7 led after reset");
        pin(remap_sel, 1'b0, "R7 remap after reset");
        pin(reset_req, 1'b0, "R8 reset_req after reset");
        pin(bus_err, 1'b0, "R11 err after reset");
        checks++;
        if (bus_rdata !== 32'h0) begin
            failures++;
            $display("FAIL R1 idle rdata actual=%h expected=0", bus_rdata);
        end

        rd(9'h000, 32'h411A3001, 0, "R1 id");
        rd(9'h010, 32'h00100000, 0, "R1 status");
        rd(9'h004, 32'h0, 0, "R1 word1");
        rd(9'h008, 32'h01000048, 0, "R4 osc reset");
        rd(9'h01C, 32'h0007FEFF, 0, "R4 aux reset");
        rd(9'h024, 32'h00000112, 0, "R4 init reset");
        rd(9'h020, 32'h0001112E, 0, "R5 sdram reset");
        rd(9'h014, 32'h0, 0, "R2 lock reset");

        // R3 locked writes ignored
        wr(9'h008, 32'h12345678, 0, "R3 locked osc write");
        rd(9'h008, 32'h01000048, 0, "R3 osc unchanged");
        // R2 unlock
        wr(9'h014, 32'hFFFFA05F, 0, "R2 lock write");
        rd(9'h014, 32'h0001A05F, 0, "R2 lock key read");
        wr(9'h008, 32'hCAFE0001, 0, "R3 unlocked osc write");
        wr(9'h01C, 32'h00000ABC, 0, "R3 unlocked aux write");
        rd(9'h008, 32'hCAFE0001, 0, "R3 osc written");
        rd(9'h01C, 32'h00000ABC, 0, "R3 aux written");
        wr(9'h014, 32'h00011234, 0, "R2 relock");
        rd(9'h014, 32'h00001234, 0, "R2 lock low16");
        wr(9'h01C, 32'h00000005, 0, "R3 relocked aux write");
        rd(9'h01C, 32'h00000ABC, 0, "R3 aux unchanged");

        // R5 plain words
        wr(9'h020, 32'hDEAD0000, 0, "R5 sdram write");
        rd(9'h020, 32'hDEAD0000, 0, "R5 sdram readback");
        wr(9'h024, 32'h00000003, 0, "R5 init write");
        rd(9'h024, 32'h00000003, 0, "R5 init readback");

        // R6 flags
        wr(9'h030, 32'h000000F0, 0, "R6 flag set");
        wr(9'h030, 32'h0000000F, 0, "R6 flag set2");
        rd(9'h030, 32'h000000FF, 0, "R6 flags or");
        wr(9'h034, 32'h0000000F, 0, "R6 flag clr");
        rd(9'h030, 32'h000000F0, 0, "R6 flags cleared");
        wr(9'h038, 32'h000000A5, 0, "R6 nv set");
        wr(9'h03C, 32'h00000005, 0, "R6 nv clr");
        rd(9'h038, 32'h000000A0, 0, "R6 nv value");

        // R7 control
        wr(9'h00C, 32'h00000005, 0, "R7 ctrl write");
        pin(led_on, 1'b1, "R7 led on");
        pin(remap_sel, 1'b1, "R7 remap on");
        rd(9'h00C, 32'h00000005, 0, "R7 ctrl readback");
        wr(9'h00C, 32'h00000004, 0, "R7 ctrl write2");
        pin(led_on, 1'b0, "R7 led off");
        pin(remap_sel, 1'b1, "R7 remap held");

        // R8 reset request
        wr(9'h00C, 32'h0000000D, 0, "R8 ctrl req write");
        pin(reset_req, 1'b1, "R8 reset_req pulse");
        pin(led_on, 1'b1, "R8 led before clear");
        @(negedge clk);
        pin(reset_req, 1'b0, "R8 reset_req one cycle");
        pin(led_on, 1'b0, "R8 led cleared");
        pin(remap_sel, 1'b0, "R8 remap cleared");
        rd(9'h030, 32'h0, 0, "R8 volatile flags cleared");
        rd(9'h038, 32'h000000A0, 0, "R8 nv flags kept");
        rd(9'h00C, 32'h0, 0, "R8 ctrl reads zero");

        // R9 identification window
        rd(9'h100, 32'h00000080, 0, "R9 byte0");
        rd(9'h108, 32'h00000004, 0, "R9 byte2");
        rd(9'h17C, 32'h00000020, 0, "R9 size byte");
        rd(9'h180, 32'h0, 0, "R9 upper zero");
        rd(9'h1FC, 32'h0, 0, "R9 upper end zero");

        // R10 voltage words
        wr(9'h080, 32'hFFFFFFFF, 0, "R10 volt write");
        rd(9'h080, 32'h0, 0, "R10 volt read");
        rd(9'h08C, 32'h0, 0, "R10 volt3 read");

        // R11 undecoded
        rd(9'h018, 32'h0, 1, "R11 undecoded read");
        pin(bus_err, 1'b1, "R11 err strobe");
        @(negedge clk);
        pin(bus_err, 1'b0, "R11 err one cycle");
        wr(9'h000, 32'h1, 1, "R11 write read-only");
        rd(9'h034, 32'h0, 1, "R11 read write-only");
        wr(9'h100, 32'h1, 1, "R11 write window");
        rd(9'h002, 32'h0, 1, "R11 unaligned");
        rd(9'h000, 32'h411A3001, 0, "R11 good after bad");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: %0d results missing", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule